// File: doc/BRIEF.md
# FFT Result Unload Sequencer

This block decides when a transform engine releases its result memory to the output port. It then turns a stream of output strobes and output enables into an address stream with a valid flag. A transform-done pulse starts a handover countdown. Once the countdown ends, and once the port has been re-initialised after the last mode change, the data-available flag rises. The consumer then supplies one priming strobe and four enable-qualified strobes to fill the output pipeline. After that, every enable-qualified strobe moves the read address on by one, until the final point of the transform has been delivered.

The strobe is the only pacing signal on the output side. A strobe that arrives without the enable stalls the stream and has no other effect, so no further back-pressure exists. The transform-size select and the single-device flag are sampled on the done pulse. Raising the mode-change input aborts any unload in progress. The port must then see four new strobes after the mode-change input returns low before data-available can rise again.

Top module: `unload_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `data_avail` and `out_valid` low, and `rd_addr` and `fill_cnt` at zero.
- R2: While `mode_chg` is high, `data_avail`, `out_valid` and `fill_cnt` are forced low or zero, and the handover restarts from waiting. After `mode_chg` falls, `data_avail` stays low until four strobes (`out_strobe`, with or without `out_enable`) have been sampled.
- R3: If the handover runs freely and the size is small, or the part is not in single-device mode, `data_avail` rises 6 clock edges after the edge that samples `xform_done`.
- R4: For the large size (1024 points) in single-device mode, the handover lasts 4 edges instead of 6.
- R5: The handover runs freely only when `single_dev` is 1 and `out_enable` is 0 on the done edge. In every other case the countdown advances only on edges where `out_strobe` is high.
- R6: While `data_avail` is high, the first strobe primes the pipeline whether or not `out_enable` is high, and sets `fill_cnt` to 1. After that, only strobes with `out_enable` high count. `out_valid` rises, with `rd_addr` = 0 and `fill_cnt` = 5, on the fourth qualified strobe, which is the fifth strobe overall.
- R7: Strobes that arrive while `data_avail` is low (during computation, during the handover, or before re-initialisation) leave `fill_cnt` at 0.
- R8: While `out_valid` is high, each edge with `out_strobe` and `out_enable` both high adds one to `rd_addr`. This holds even with a strobe on every clock. Any other edge leaves `rd_addr` unchanged.
- R9: A qualified strobe at the last address (255 for the small size, 1023 for the large size) clears `out_valid` and `data_avail` and returns `rd_addr` and `fill_cnt` to 0. A `xform_done` that arrives before that edge, or on it, is ignored.
- R10: If the transform finishes before the post-mode-change strobes are complete, `data_avail` stays low. It rises on the edge that samples the fourth such strobe, provided the handover has already elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_strobe | input | 1 | Output strobe |
| out_enable | input | 1 | Output enable qualifying the strobe |
| mode_chg | input | 1 | Mode change in progress |
| big_size | input | 1 | 1 = large (1024-point) transform, 0 = small (256-point) |
| single_dev | input | 1 | 1 = single-device operation |
| xform_done | input | 1 | One-cycle pulse when the transform finishes |
| data_avail | output | 1 | Result memory owned by the output port |
| out_valid | output | 1 | Data for `rd_addr` is on the pins |
| rd_addr | output | 10 | Read address of the point being presented |
| fill_cnt | output | 3 | Strobes counted toward the pipeline fill |

## Verification
The delivery of the last point and a new done pulse can fall on the same clock edge. Separately, a qualified strobe and a mode change can collide. The bench drives `xform_done` high in the same cycle as the qualified strobe at address 255. It then checks that the unload ends cleanly and that `data_avail` stays low for ten more cycles, which shows the done pulse was dropped and not queued. It also raises `mode_chg` together with a qualified strobe in the middle of a stream. It then checks that the abort wins over the address step, and that a later transform still waits for four new strobes.

// File: rtl/unload_pkg.sv
package unload_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_HAND  = 2'd1,
    PH_AVAIL = 2'd2
  } phase_e;
endpackage

// File: rtl/unload_init_gate.sv
// Counts strobes after a mode change; opens once enough have been seen.
module unload_init_gate #(
  parameter int STROBES = 4,
  parameter int CW      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic def_i,
  input  logic dos_i,
  output logic ready_o
);
  generate
    if (STROBES == 0) begin : g_none
      logic unused_ok;
      assign unused_ok = clk ^ rst ^ def_i ^ dos_i;
      assign ready_o   = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || def_i)                       cnt <= '0;
        else if (dos_i && cnt != CW'(STROBES))  cnt <= cnt + 1'b1;
      end
      assign ready_o = (cnt == CW'(STROBES));
    end
  endgenerate
endmodule

// File: rtl/unload_hand_timer.sv
// Handover countdown: free-running or strobe-paced, length set by size/mode.
module unload_hand_timer #(
  parameter int STD_LEN   = 6,
  parameter int LARGE_LEN = 4,
  parameter int CW        = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic abort_i,
  input  logic load_i,
  input  logic active_i,
  input  logic big_i,
  input  logic single_i,
  input  logic den_i,
  input  logic dos_i,
  output logic expire_o
);
  logic [CW-1:0] cnt;
  logic          free_run;
  logic          tick;

  assign tick     = free_run | dos_i;
  assign expire_o = active_i && tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      cnt      <= '0;
      free_run <= 1'b0;
    end else if (load_i) begin
      cnt      <= (big_i && single_i) ? CW'(LARGE_LEN) : CW'(STD_LEN);
      free_run <= single_i && !den_i;
    end else if (active_i && tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/unload_stream.sv
// Pipeline fill (prime + qualified strobes) and read-address stream.
module unload_stream #(
  parameter int SMALL_PTS = 256,
  parameter int LARGE_PTS = 1024,
  parameter int FILL      = 4,
  parameter int AW        = 10,
  parameter int FW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          big_i,
  input  logic          dos_i,
  input  logic          den_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [FW-1:0] fill_o,
  output logic          last_o
);
  localparam logic [AW-1:0] SMALL_LAST = AW'(SMALL_PTS - 1);
  localparam logic [AW-1:0] LARGE_LAST = AW'(LARGE_PTS - 1);

  logic          step, qual;
  logic [AW-1:0] last_addr;

  assign step      = en_i && dos_i;
  assign qual      = step && den_i;
  assign last_addr = big_i ? LARGE_LAST : SMALL_LAST;
  assign last_o    = valid_o && qual && (addr_o == last_addr);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      fill_o  <= '0;
    end else if (step) begin
      if (!valid_o) begin
        if (fill_o == '0) begin
          fill_o <= FW'(1);
        end else if (den_i) begin
          fill_o <= fill_o + 1'b1;
          if (fill_o == FW'(FILL)) begin
            valid_o <= 1'b1;
            addr_o  <= '0;
          end
        end
      end else if (den_i) begin
        if (last_o) begin
          valid_o <= 1'b0;
          addr_o  <= '0;
          fill_o  <= '0;
        end else begin
          addr_o <= addr_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/unload_seq.sv
module unload_seq #(
  parameter int SMALL_PTS    = 256,
  parameter int LARGE_PTS    = 1024,
  parameter int HAND_STD     = 6,
  parameter int HAND_LARGE   = 4,
  parameter int FILL_QUAL    = 4,
  parameter int INIT_STROBES = 4,
  parameter int AW           = $clog2(LARGE_PTS),
  parameter int FW           = $clog2(FILL_QUAL + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_strobe,
  input  logic          out_enable,
  input  logic          mode_chg,
  input  logic          big_size,
  input  logic          single_dev,
  input  logic          xform_done,
  output logic          data_avail,
  output logic          out_valid,
  output logic [AW-1:0] rd_addr,
  output logic [FW-1:0] fill_cnt
);
  import unload_pkg::*;

  localparam int HMAX = (HAND_STD > HAND_LARGE) ? HAND_STD : HAND_LARGE;
  localparam int HW   = $clog2(HMAX + 1);
  localparam int IW   = $clog2(INIT_STROBES + 1);

  phase_e phase;
  logic   big_q;
  logic   init_ready, hand_expire, stream_last, load_hand;

  assign load_hand  = (phase == PH_WAIT) && xform_done;
  assign data_avail = (phase == PH_AVAIL) && init_ready;

  always_ff @(posedge clk) begin
    if (rst || mode_chg) begin
      phase <= PH_WAIT;
      big_q <= 1'b0;
    end else begin
      case (phase)
        PH_WAIT:  if (xform_done) begin
                    phase <= PH_HAND;
                    big_q <= big_size;
                  end
        PH_HAND:  if (hand_expire) phase <= PH_AVAIL;
        PH_AVAIL: if (stream_last) phase <= PH_WAIT;
        default:  phase <= PH_WAIT;
      endcase
    end
  end

  unload_init_gate #(.STROBES(INIT_STROBES), .CW(IW)) u_init (
    .clk(clk), .rst(rst), .def_i(mode_chg), .dos_i(out_strobe),
    .ready_o(init_ready)
  );

  unload_hand_timer #(.STD_LEN(HAND_STD), .LARGE_LEN(HAND_LARGE), .CW(HW)) u_hand (
    .clk(clk), .rst(rst), .abort_i(mode_chg), .load_i(load_hand),
    .active_i(phase == PH_HAND), .big_i(big_size), .single_i(single_dev),
    .den_i(out_enable), .dos_i(out_strobe), .expire_o(hand_expire)
  );

  unload_stream #(.SMALL_PTS(SMALL_PTS), .LARGE_PTS(LARGE_PTS), .FILL(FILL_QUAL),
                  .AW(AW), .FW(FW)) u_stream (
    .clk(clk), .rst(rst), .clr_i(mode_chg || phase != PH_AVAIL),
    .en_i(data_avail), .big_i(big_q), .dos_i(out_strobe), .den_i(out_enable),
    .valid_o(out_valid), .addr_o(rd_addr), .fill_o(fill_cnt), .last_o(stream_last)
  );
endmodule

// File: rtl/unload_seq_chk.sv
module unload_seq_chk #(
  parameter int LARGE_PTS = 1024,
  parameter int SMALL_PTS = 256,
  parameter int FILL_QUAL = 4,
  parameter int AW        = 10,
  parameter int FW        = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          out_strobe,
  input logic          out_enable,
  input logic          mode_chg,
  input logic          data_avail,
  input logic          out_valid,
  input logic [AW-1:0] rd_addr,
  input logic [FW-1:0] fill_cnt
);
  p_valid_in_avail_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> data_avail);

  p_rise_on_qual_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(out_strobe && out_enable));

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= FW'(FILL_QUAL + 1));

  p_dark_fill_r7: assert property (@(posedge clk) disable iff (rst)
    !data_avail |-> fill_cnt == '0);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_strobe && out_enable && !mode_chg && rd_addr < AW'(SMALL_PTS - 1))
    |=> rd_addr == $past(rd_addr) + 1'b1);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_strobe && out_enable) && !mode_chg)
    |=> out_valid && $stable(rd_addr));

  p_def_clears_r2: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !data_avail && !out_valid && fill_cnt == '0);

  p_def_fall_dark_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_chg) |=> !data_avail);

  p_last_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_strobe && out_enable && !mode_chg && rd_addr == AW'(LARGE_PTS - 1))
    |=> !data_avail && !out_valid);
endmodule

bind unload_seq unload_seq_chk #(
  .LARGE_PTS(LARGE_PTS), .SMALL_PTS(SMALL_PTS), .FILL_QUAL(FILL_QUAL), .AW(AW), .FW(FW)
) u_chk (
  .clk(clk), .rst(rst), .out_strobe(out_strobe), .out_enable(out_enable),
  .mode_chg(mode_chg), .data_avail(data_avail), .out_valid(out_valid),
  .rd_addr(rd_addr), .fill_cnt(fill_cnt)
);

// File: tb/tb_unload_seq.sv
`timescale 1ns/1ps
module tb_unload_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       out_strobe = 1'b0, out_enable = 1'b0, mode_chg = 1'b0;
  logic       big_size = 1'b0, single_dev = 1'b1, xform_done = 1'b0;
  logic       data_avail, out_valid;
  logic [9:0] rd_addr;
  logic [2:0] fill_cnt;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  unload_seq dut (
    .clk(clk), .rst(rst), .out_strobe(out_strobe), .out_enable(out_enable),
    .mode_chg(mode_chg), .big_size(big_size), .single_dev(single_dev),
    .xform_done(xform_done), .data_avail(data_avail), .out_valid(out_valid),
    .rd_addr(rd_addr), .fill_cnt(fill_cnt)
  );

  // handover table: size, single, enable at done, strobe held, expected edges (0 = never)
  typedef struct packed {
    logic big; logic single; logic den; logic dos; logic [1:0] tag; logic [7:0] expect_edges;
  } hvec_t;
  localparam int NV = 7;
  localparam hvec_t HV [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd6},
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 8'd4},
    '{1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'd6},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 8'd6},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 8'd0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 8'd4}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe(input logic en);
    out_strobe = 1'b1; out_enable = en;
    tick();
    out_strobe = 1'b0; out_enable = 1'b0;
  endtask

  task automatic remode();
    mode_chg = 1'b1; tick(); mode_chg = 1'b0;
    for (int i = 0; i < 4; i++) strobe(1'b0);
  endtask

  task automatic fire_done(input logic big, input logic single, input logic en);
    big_size = big; single_dev = single; out_enable = en; xform_done = 1'b1;
    tick();
    xform_done = 1'b0; out_enable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seen;
    int bad;
    string tg;
    // R1 reset
    out_strobe = 1'b1; out_enable = 1'b1;
    repeat (3) tick();
    out_strobe = 1'b0; out_enable = 1'b0;
    chk("R1", "dav", data_avail, 0);
    chk("R1", "valid", out_valid, 0);
    chk("R1", "addr+fill", int'(rd_addr) + int'(fill_cnt), 0);
    rst = 1'b0;
    tick();

    // handover table
    for (int i = 0; i < NV; i++) begin
      remode();
      fire_done(HV[i].big, HV[i].single, HV[i].den);
      out_strobe = HV[i].dos;
      seen = 0;
      for (int c = 1; c <= 12; c++) begin
        tick();
        if (data_avail && seen == 0) seen = c;
      end
      out_strobe = 1'b0;
      tg = (HV[i].tag == 2'd0) ? "R3" : (HV[i].tag == 2'd1) ? "R4" : "R5";
      chk(tg, "handover edges", seen, int'(HV[i].expect_edges));
    end

    // R10 done before re-init strobes complete
    mode_chg = 1'b1; tick(); mode_chg = 1'b0;
    fire_done(1'b0, 1'b1, 1'b0);
    repeat (8) tick();
    chk("R10", "dav before strobes", data_avail, 0);
    for (int i = 0; i < 3; i++) strobe(1'b1);
    chk("R2", "dav after 3 strobes", data_avail, 0);
    strobe(1'b1);
    chk("R10", "dav after 4th strobe", data_avail, 1);
    chk("R7", "fill untouched", fill_cnt, 0);

    // R6 same-cycle enable and strobe: fifth pulse presents data
    bad = 0;
    for (int i = 1; i <= 4; i++) begin
      strobe(1'b1);
      if (fill_cnt != 3'(i) || out_valid) bad++;
    end
    chk("R6", "fill ramp mismatches", bad, 0);
    strobe(1'b1);
    chk("R6", "valid on 5th", out_valid, 1);
    chk("R6", "addr0/fill5", int'(rd_addr) * 8 + int'(fill_cnt), 5);

    // R8 stepping and stalls
    for (int i = 0; i < 10; i++) strobe(1'b1);
    chk("R8", "addr after 10", rd_addr, 10);
    for (int i = 0; i < 3; i++) strobe(1'b0);
    out_enable = 1'b1; tick(); out_enable = 1'b0;
    chk("R8", "addr held", rd_addr, 10);
    for (int i = 0; i < 245; i++) strobe(1'b1);
    chk("R8", "addr at last", rd_addr, 255);
    // R9 last point with a colliding done pulse
    xform_done = 1'b1; strobe(1'b1); xform_done = 1'b0;
    chk("R9", "valid dropped", out_valid, 0);
    chk("R9", "dav dropped", data_avail, 0);
    chk("R9", "addr+fill reset", int'(rd_addr) + int'(fill_cnt), 0);
    repeat (10) tick();
    chk("R9", "done ignored", data_avail, 0);

    // R7 strobes during compute and handover
    for (int i = 0; i < 5; i++) strobe(1'b1);
    chk("R7", "fill while computing", fill_cnt, 0);
    fire_done(1'b0, 1'b1, 1'b0);
    out_strobe = 1'b1; out_enable = 1'b1;
    repeat (6) tick();
    out_strobe = 1'b0; out_enable = 1'b0;
    chk("R7", "dav after handover", data_avail, 1);
    chk("R7", "fill after handover", fill_cnt, 0);
    // R6 prime without enable, then enable
    strobe(1'b0);
    strobe(1'b0);
    out_enable = 1'b1; tick(); out_enable = 1'b0;
    chk("R6", "prime only once", fill_cnt, 1);
    for (int i = 0; i < 3; i++) strobe(1'b1);
    chk("R6", "not yet valid", int'(out_valid) * 8 + int'(fill_cnt), 4);
    strobe(1'b1);
    chk("R6", "valid on 4th qualified", out_valid, 1);

    // R2 mode change collides with a qualified strobe
    strobe(1'b1);
    mode_chg = 1'b1; out_strobe = 1'b1; out_enable = 1'b1;
    tick();
    mode_chg = 1'b0; out_strobe = 1'b0; out_enable = 1'b0;
    chk("R2", "abort valid/dav", int'(out_valid) + int'(data_avail), 0);
    chk("R2", "abort addr+fill", int'(rd_addr) + int'(fill_cnt), 0);
    fire_done(1'b0, 1'b1, 1'b0);
    repeat (8) tick();
    chk("R2", "no dav without strobes", data_avail, 0);

    // R4/R8/R9 large transform at full strobe rate
    remode();
    fire_done(1'b1, 1'b1, 1'b0);
    repeat (4) tick();
    chk("R4", "large dav", data_avail, 1);
    bad = 0;
    out_strobe = 1'b1; out_enable = 1'b1;
    for (int s = 1; s <= 1028; s++) begin
      tick();
      if (s >= 5 && (!out_valid || rd_addr != 10'(s - 5))) bad++;
    end
    chk("R8", "full-rate address errors", bad, 0);
    tick();
    out_strobe = 1'b0; out_enable = 1'b0;
    chk("R9", "large end valid+dav", int'(out_valid) + int'(data_avail), 0);

    summary();
  end
endmodule